// File: doc/BRIEF.md
# Time-Stamp Capture on an External Trigger Pin

This block records the current protocol time whenever a chosen edge arrives on an external trigger pin. Any one of a bank of general-purpose pins can act as the trigger. Each pin has its own function word in a small register space. A pin becomes the trigger source only when its function word has the enable bit set, the timing-function bit set, and the trigger signal code in its low field. Every pin is passed through its own synchronizer and edge detector. The edge that counts is chosen by one polarity bit, either rising or falling, and never both at once.

When the selected edge is detected, a single capture slot latches the 32-bit nanoseconds and 32-bit seconds values presented on the time inputs. Software reads the capture as four 16-bit words and then writes a done bit to release the slot. A sticky valid flag shows that a capture has arrived since the last release. If a later edge arrives before that release, it overwrites the held capture. The time counter is an input to this block. The management bus framing is outside it.

Top module: `ptp_trig_capture`

## Requirements
- R1: After reset every readable register is zero: capture words, valid flag, polarity bit and all pin function words.
- R2: The function word of pin i is a 16-bit read/write register at address 0x20+i, for pins 0 to 11. A pin triggers captures only when bit 15 is 1, bit 6 is 1 and bits [5:0] equal 0x01. Any other value, including 0 and 0x8052, gives no capture.
- R3: Bit 1 of the register at address 0x00 selects the edge: 0 captures on rising edges only and 1 on falling edges only. The other bits of that register read as 0.
- R4: Each pin passes through two synchronizing flops. Suppose a pin changes before clock edge k. The captured values then equal the time inputs presented between clock edges k+1 and k+2.
- R5: The capture reads back at these addresses: 0x10 gives nanoseconds [15:0], 0x11 gives nanoseconds [31:16], 0x12 gives seconds [15:0] and 0x13 gives seconds [31:16]. Address 0x14 always reads 0.
- R6: Bit 0 of the register at address 0x15 reads the valid flag. A capture sets the flag. A write with bit 0 = 1 clears it, and a write with bit 0 = 0 leaves it unchanged. When a capture and a clearing write happen in the same cycle, the flag ends up set.
- R7: An edge that arrives before the release overwrites the held capture. Without a new capture the words stay unchanged, including across the release write.
- R8: If several pins are set up as triggers, only the lowest-numbered one is used. Edges on the others are ignored.
- R9: Addresses that are not listed read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| gpio_i | input | 12 | Asynchronous general-purpose pin inputs |
| time_ns_i | input | 32 | Nanoseconds from the local time counter |
| time_sec_i | input | 32 | Seconds from the local time counter |
| reg_addr_i | input | 8 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |

## Verification
The hardest case to reach is a release write that lands in the same clock cycle as a detected edge. The write must hit the one cycle that follows the second synchronizer flop. The bench therefore drives the time inputs and the pins itself, one step per falling clock edge, and places the release write on the third step after the pin change. It then expects the valid flag to stay set. Each step of the time inputs carries a distinct value, so the single value that is captured shows exactly which cycle the detector acted on. A second sequence sends two edges without a release in between, to show that the later edge overwrites the first.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 8;
  localparam int TS_W   = 2 * REG_W;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CFG     = 8'h00;
  localparam logic [ADDR_W-1:0] A_NS_LO   = 8'h10;
  localparam logic [ADDR_W-1:0] A_NS_HI   = 8'h11;
  localparam logic [ADDR_W-1:0] A_SEC_LO  = 8'h12;
  localparam logic [ADDR_W-1:0] A_SEC_HI  = 8'h13;
  localparam logic [ADDR_W-1:0] A_PAD     = 8'h14;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h15;
  localparam logic [ADDR_W-1:0] A_FUNC_BASE = 8'h20;

  // field positions
  localparam int EDGE_BIT      = 1;
  localparam int DONE_BIT      = 0;
  localparam int FUNC_EN_BIT   = 15;
  localparam int FUNC_TIME_BIT = 6;
  localparam int SIG_W         = 6;
  localparam logic [SIG_W-1:0] SIG_TRIGGER = 6'h01;

  function automatic logic [ADDR_W-1:0] func_addr(input int idx);
    return A_FUNC_BASE + ADDR_W'(idx);
  endfunction

  function automatic logic is_trigger(input logic [REG_W-1:0] cfg);
    return cfg[FUNC_EN_BIT] && cfg[FUNC_TIME_BIT] && (cfg[SIG_W-1:0] == SIG_TRIGGER);
  endfunction
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // bits [SYNC_STAGES-1:0] synchronize, bit SYNC_STAGES holds the prior level
  logic [SYNC_STAGES:0] stage_q;
  logic [SYNC_STAGES:0] stage_d;

  always_comb begin
    stage_d = {stage_q[SYNC_STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rise_o =  stage_q[SYNC_STAGES-1] & ~stage_q[SYNC_STAGES];
  assign fall_o = ~stage_q[SYNC_STAGES-1] &  stage_q[SYNC_STAGES];
endmodule

// File: rtl/trig_src_select.sv
module trig_src_select
  import trig_pkg::*;
#(
  parameter int NUM_PINS = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PINS-1:0][REG_W-1:0] func_cfg_i,
  input  logic [NUM_PINS-1:0]            rise_i,
  input  logic [NUM_PINS-1:0]            fall_i,
  input  logic                           fall_mode_i,
  output logic                           hit_o
);
  logic [NUM_PINS-1:0] sel_vec;
  logic [NUM_PINS-1:0] edge_vec;

  // lowest index wins: scan downward so the last match is the lowest pin
  always_comb begin
    sel_vec = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (is_trigger(func_cfg_i[i])) begin
        sel_vec    = '0;
        sel_vec[i] = 1'b1;
      end
    end
  end

  assign edge_vec = fall_mode_i ? fall_i : rise_i;
  assign hit_o    = |(sel_vec & edge_vec);

  // R8: at most one pin feeds the capture slot
  p_single_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));

  // R2: a capture needs a configured trigger pin
  p_hit_needs_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (sel_vec != '0));
endmodule

// File: rtl/trig_capture_slot.sv
module trig_capture_slot
  import trig_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit_i,
  input  logic            ack_i,
  input  logic [TS_W-1:0] time_ns_i,
  input  logic [TS_W-1:0] time_sec_i,
  output logic [TS_W-1:0] cap_ns_o,
  output logic [TS_W-1:0] cap_sec_o,
  output logic            valid_o
);
  logic [TS_W-1:0] cap_ns_q,  cap_ns_d;
  logic [TS_W-1:0] cap_sec_q, cap_sec_d;
  logic            valid_q,   valid_d;
  logic            cap_en;

  assign cap_en = hit_i;

  always_comb begin
    cap_ns_d  = time_ns_i;
    cap_sec_d = time_sec_i;
    valid_d   = valid_q;
    if (ack_i) valid_d = 1'b0;
    if (hit_i) valid_d = 1'b1;   // a new capture outranks a release
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_ns_q  <= '0;
      cap_sec_q <= '0;
    end else if (cap_en) begin
      cap_ns_q  <= cap_ns_d;
      cap_sec_q <= cap_sec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign cap_ns_o  = cap_ns_q;
  assign cap_sec_o = cap_sec_q;
  assign valid_o   = valid_q;

  // R4: the slot holds the time presented in the detection cycle
  p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> (cap_ns_o == $past(time_ns_i)) && (cap_sec_o == $past(time_sec_i)));

  // R7: without a capture the words do not move
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_i |=> $stable(cap_ns_o) && $stable(cap_sec_o));

  // R6: capture sets the flag, even against a release
  p_valid_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> valid_o);

  // R6: a release without a capture clears the flag
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !hit_i) |=> !valid_o);
endmodule

// File: rtl/ptp_trig_capture.sv
module ptp_trig_capture
  import trig_pkg::*;
#(
  parameter int NUM_PINS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   gpio_i,
  input  logic [TS_W-1:0]       time_ns_i,
  input  logic [TS_W-1:0]       time_sec_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic                  reg_we_i,
  input  logic [REG_W-1:0]      reg_wdata_i,
  output logic [REG_W-1:0]      reg_rdata_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  // polarity register
  logic fall_mode_q, fall_mode_d;
  logic cfg_we;

  assign cfg_we = reg_we_i && (reg_addr_i == A_CFG);

  always_comb begin
    fall_mode_d = reg_wdata_i[EDGE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    fall_mode_q <= 1'b0;
    else if (cfg_we) fall_mode_q <= fall_mode_d;
  end

  // per-pin function words and edge detectors
  logic [NUM_PINS-1:0][REG_W-1:0] func_all;
  logic [NUM_PINS-1:0]            rise_v;
  logic [NUM_PINS-1:0]            fall_v;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [REG_W-1:0] func_q;
    logic             func_we;

    assign func_we = reg_we_i && (reg_addr_i == func_addr(g));

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s)     func_q <= '0;
      else if (func_we) func_q <= reg_wdata_i;
    end

    assign func_all[g] = func_q;

    trig_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .pin_i  (gpio_i[g]),
      .rise_o (rise_v[g]),
      .fall_o (fall_v[g])
    );
  end

  // trigger source and capture slot
  logic            hit;
  logic            ack;
  logic [TS_W-1:0] cap_ns;
  logic [TS_W-1:0] cap_sec;
  logic            cap_valid;

  trig_src_select #(.NUM_PINS(NUM_PINS)) i_select (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .func_cfg_i  (func_all),
    .rise_i      (rise_v),
    .fall_i      (fall_v),
    .fall_mode_i (fall_mode_q),
    .hit_o       (hit)
  );

  assign ack = reg_we_i && (reg_addr_i == A_CTRL) && reg_wdata_i[DONE_BIT];

  trig_capture_slot i_slot (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .hit_i      (hit),
    .ack_i      (ack),
    .time_ns_i  (time_ns_i),
    .time_sec_i (time_sec_i),
    .cap_ns_o   (cap_ns),
    .cap_sec_o  (cap_sec),
    .valid_o    (cap_valid)
  );

  // read mux
  logic [REG_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    case (reg_addr_i)
      A_CFG:    rdata_d[EDGE_BIT] = fall_mode_q;
      A_NS_LO:  rdata_d = cap_ns[REG_W-1:0];
      A_NS_HI:  rdata_d = cap_ns[TS_W-1:REG_W];
      A_SEC_LO: rdata_d = cap_sec[REG_W-1:0];
      A_SEC_HI: rdata_d = cap_sec[TS_W-1:REG_W];
      A_CTRL:   rdata_d[DONE_BIT] = cap_valid;
      default: begin
        for (int i = 0; i < NUM_PINS; i++) begin
          if (reg_addr_i == func_addr(i)) rdata_d = func_all[i];
        end
      end
    endcase
  end

  assign reg_rdata_o = rdata_d;

  // R5: the padding word never carries data
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_addr_i == A_PAD) |-> (reg_rdata_o == '0));
endmodule

// File: tb/test_ptp_trig_capture.sv
module test_ptp_trig_capture;
  import trig_pkg::*;

  localparam int NPINS = 12;
  localparam int NVEC  = 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NPINS-1:0]  gpio;
  logic [31:0]       tns, tsec;
  logic [7:0]        addr;
  logic              we;
  logic [15:0]       wdata;
  logic [15:0]       rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] exp_ns  = '0;
  logic [31:0] exp_sec = '0;

  always #4 clk = ~clk;   // 125 MHz

  ptp_trig_capture #(.NUM_PINS(NPINS)) i_ptp_trig_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .gpio_i      (gpio),
    .time_ns_i   (tns),
    .time_sec_i  (tsec),
    .reg_addr_i  (addr),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata)
  );

  typedef struct packed {
    logic [3:0]  pin;
    logic [15:0] func;
    logic        fall;
    logic        hit_exp;
    logic [31:0] base;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  16'h8041, 1'b0, 1'b1, 32'h0000_1000},
    '{4'd11, 16'h8041, 1'b1, 1'b1, 32'h2000_0000},
    '{4'd5,  16'h8052, 1'b0, 1'b0, 32'h0000_3000},
    '{4'd3,  16'h0041, 1'b0, 1'b0, 32'h0000_4000},
    '{4'd7,  16'h8001, 1'b1, 1'b0, 32'h0000_5000},
    '{4'd2,  16'h8041, 1'b1, 1'b1, 32'hFFFF_FF00},
    '{4'd9,  16'h8041, 1'b0, 1'b1, 32'h1234_5678}
  };

  function automatic logic [31:0] ns_at(input logic [31:0] b, input int s);
    return b + 32'(s);
  endfunction

  function automatic logic [31:0] sec_at(input logic [31:0] b, input int s);
    return ~b + 32'(s);
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  // drive one pin level; time inputs step once per falling clock edge
  task automatic fire(input int pin, input logic level, input logic [31:0] b, input bit ack_mid);
    @(negedge clk);
    gpio[pin] = level; tns = ns_at(b, 0); tsec = sec_at(b, 0);
    @(negedge clk);
    tns = ns_at(b, 1); tsec = sec_at(b, 1);
    @(negedge clk);
    tns = ns_at(b, 2); tsec = sec_at(b, 2);
    if (ack_mid) begin addr = A_CTRL; wdata = 16'h0001; we = 1'b1; end
    @(negedge clk);
    tns = ns_at(b, 3); tsec = sec_at(b, 3);
    we = 1'b0;
    @(negedge clk);
    tns = ns_at(b, 4); tsec = sec_at(b, 4);
  endtask

  task automatic check_capture(input string tag, input logic [31:0] ens,
                               input logic [31:0] esec, input logic evalid);
    logic [15:0] lo, hi, c;
    rd(A_NS_LO, lo);  rd(A_NS_HI, hi);
    check({tag, " ns"}, {hi, lo}, ens);
    rd(A_SEC_LO, lo); rd(A_SEC_HI, hi);
    check({tag, " sec"}, {hi, lo}, esec);
    rd(A_CTRL, c);
    check({tag, " valid"}, {31'b0, c[0]}, {31'b0, evalid});
    check({tag, " ctrl upper bits"}, {16'b0, c[15:1], 1'b0}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] eb;
    rst_n = 1'b0; gpio = '0; tns = '0; tsec = '0; addr = '0; we = 1'b0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    check_capture("R1 reset", 32'h0, 32'h0, 1'b0);
    rd(A_CFG, d);            check("R1 polarity reset", {16'b0, d}, 32'h0);
    rd(func_addr(0), d);     check("R1 pin0 function reset", {16'b0, d}, 32'h0);
    rd(func_addr(11), d);    check("R1 pin11 function reset", {16'b0, d}, 32'h0);

    // R9: unlisted address
    wr(8'h30, 16'hBEEF);
    rd(8'h30, d);            check("R9 unlisted read", {16'b0, d}, 32'h0);
    // R3: only bit 1 is kept
    wr(A_CFG, 16'hFFFF);
    rd(A_CFG, d);            check("R3 polarity readback", {16'b0, d}, 32'h0000_0002);
    wr(A_CFG, 16'h0000);
    // R2: function word readback
    wr(func_addr(5), 16'h8052);
    rd(func_addr(5), d);     check("R2 function readback", {16'b0, d}, 32'h0000_8052);
    wr(func_addr(5), 16'h0000);

    // table of pin, function word, polarity and expected capture
    for (int v = 0; v < NVEC; v++) begin
      wr(func_addr(int'(VECS[v].pin)), VECS[v].func);
      wr(A_CFG, {14'b0, VECS[v].fall, 1'b0});
      wr(A_CTRL, 16'h0001);
      fire(int'(VECS[v].pin), 1'b1, VECS[v].base, 1'b0);
      fire(int'(VECS[v].pin), 1'b0, VECS[v].base + 32'd100, 1'b0);
      if (VECS[v].hit_exp) begin
        eb = VECS[v].fall ? VECS[v].base + 32'd100 : VECS[v].base;
        exp_ns  = ns_at(eb, 2);
        exp_sec = sec_at(eb, 2);
      end
      check_capture($sformatf("R2/R3/R4 vector %0d", v), exp_ns, exp_sec, VECS[v].hit_exp);
      wr(func_addr(int'(VECS[v].pin)), 16'h0000);
    end

    // R5: padding word reads zero while a capture is held
    rd(A_PAD, d);            check("R5 padding word", {16'b0, d}, 32'h0);

    // R6: write without done bit keeps the flag; with it clears the flag
    wr(func_addr(0), 16'h8041);
    wr(A_CFG, 16'h0000);
    wr(A_CTRL, 16'h0001);
    fire(0, 1'b1, 32'h0000_0500, 1'b0);
    fire(0, 1'b0, 32'h0000_0600, 1'b0);
    exp_ns = ns_at(32'h500, 2); exp_sec = sec_at(32'h500, 2);
    wr(A_CTRL, 16'h0000);
    check_capture("R6 write without done bit", exp_ns, exp_sec, 1'b1);
    wr(A_CTRL, 16'h0001);
    check_capture("R6/R7 release keeps words", exp_ns, exp_sec, 1'b0);

    // R7: second edge before release overwrites
    fire(0, 1'b1, 32'h0000_0700, 1'b0);
    fire(0, 1'b0, 32'h0000_0800, 1'b0);
    fire(0, 1'b1, 32'h0000_0900, 1'b0);
    exp_ns = ns_at(32'h900, 2); exp_sec = sec_at(32'h900, 2);
    check_capture("R7 overwrite", exp_ns, exp_sec, 1'b1);

    // R6: release in the detection cycle, capture wins
    fire(0, 1'b0, 32'h0000_0A00, 1'b0);
    wr(A_CTRL, 16'h0001);
    fire(0, 1'b1, 32'h0000_0B00, 1'b1);
    exp_ns = ns_at(32'hB00, 2); exp_sec = sec_at(32'hB00, 2);
    check_capture("R6 capture beats release", exp_ns, exp_sec, 1'b1);
    fire(0, 1'b0, 32'h0000_0C00, 1'b0);
    wr(func_addr(0), 16'h0000);

    // R8: lowest configured pin wins
    wr(func_addr(4), 16'h8041);
    wr(func_addr(8), 16'h8041);
    wr(A_CTRL, 16'h0001);
    fire(8, 1'b1, 32'h0000_0D00, 1'b0);
    fire(8, 1'b0, 32'h0000_0E00, 1'b0);
    check_capture("R8 higher pin ignored", exp_ns, exp_sec, 1'b0);
    fire(4, 1'b1, 32'h0000_0F00, 1'b0);
    exp_ns = ns_at(32'hF00, 2); exp_sec = sec_at(32'hF00, 2);
    check_capture("R8 lowest pin used", exp_ns, exp_sec, 1'b1);
    fire(4, 1'b0, 32'h0000_1100, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule